// File: doc/BRIEF.md
# Framebuffer Write Snooper and Address Translator

This block listens, without ever driving or stalling it, to a 16-bit 68000-style CPU bus and picks out each write that falls inside the video framebuffer of a compact machine's memory map. The framebuffer does not sit at a fixed address. It lies a fixed distance below the top of installed RAM, and that top is chosen by a static 3-bit configuration input. Two display pages exist: a primary page and an alternate page, each at its own distance below the RAM top.

For each captured write, the block issues a one-cycle request. The request carries a zero-based word address inside the selected page, a bit that says which page was written, the 16-bit data and the two byte enables. A downstream video memory controller consumes these requests. A page-select input is passed through and reported as the page being displayed. Writes to both pages are captured, whichever page is displayed. All bus inputs are asynchronous and pass through a synchronizer of parameterised depth.

Top module: `fb_snoop`

## Requirements
- R1: Configuration codes 0 to 5 select RAM tops 0x020000, 0x080000, 0x100000, 0x200000, 0x280000 and 0x400000. The primary page begins 0x5900 bytes below the selected top. A write to the first byte of the primary page yields word address 0 with page bit 0.
- R2: The alternate page begins 0xD900 bytes below the RAM top. A write there yields word address 0 with page bit 1. For the 0x400000 top, this is byte address 0x3F2700.
- R3: Each page is 21,888 bytes long. Word address = (byte address − page base) / 2, so the range is 0 to 10943. The last word of a page is captured. The byte just past the end is not captured, and neither is the byte just below the base.
- R4: Configuration codes 6 and 7 are invalid. While one of them is applied, `cfg_invalid` is 1 and no request is issued.
- R5: A bus cycle with `bus_rw` = 1 (read) never issues a request.
- R6: `wr_be[1]` is 1 when the upper data strobe (`bus_uds_n`) is low. `wr_be[0]` is 1 when the lower data strobe (`bus_lds_n`) is low. `wr_data` equals the bus data unchanged.
- R7: Exactly one request is issued per bus cycle, meaning per low period of `bus_as_n`, however long that period lasts.
- R8: `disp_page` follows `page_sel`. Writes to either page are captured regardless of `page_sel`.
- R9: After reset, `wr_valid` is 0.
- R10: `wr_valid` is a single-cycle pulse.
- R11: A bus cycle in which both data strobes stay high issues no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| cfg_ram_sel | input | 3 | RAM size code (static) |
| page_sel | input | 1 | Displayed page, 0 primary, 1 alternate |
| bus_as_n | input | 1 | Address strobe, active low |
| bus_rw | input | 1 | 1 read, 0 write |
| bus_uds_n | input | 1 | Upper data strobe, active low |
| bus_lds_n | input | 1 | Lower data strobe, active low |
| bus_addr | input | 23 | Word address bits 23..1 |
| bus_data | input | 16 | Bus data |
| cfg_invalid | output | 1 | Configuration code is invalid |
| disp_page | output | 1 | Page reported as displayed |
| wr_valid | output | 1 | Write request pulse |
| wr_page | output | 1 | Page written, 0 primary, 1 alternate |
| wr_addr | output | 14 | Word address inside the page |
| wr_data | output | 16 | Write data |
| wr_be | output | 2 | Byte enables, bit 1 upper |

## Verification
The bench keeps the default page length and page offsets. It builds the block with a three-stage synchronizer, so every request lags the bus by one more cycle than with the default two stages. This shows that the one-request-per-cycle rule and the re-arm on address-strobe release do not depend on synchronizer depth. The default geometry keeps every RAM top, both page bases, the last word at 10943 and the out-of-window neighbours within reach of short directed bus cycles.

// File: rtl/fb_snoop_pkg.sv
package fb_snoop_pkg;
    localparam int BUS_AW = 24;
    localparam int DATA_W = 16;
    localparam int CFG_W  = 3;

    typedef struct packed {
        logic              as_n;
        logic              rw;
        logic              uds_n;
        logic              lds_n;
        logic [BUS_AW-1:1] addr;
        logic [DATA_W-1:0] data;
    } bus_t;

    localparam int   BUS_BITS = $bits(bus_t);
    localparam bus_t BUS_IDLE = '{as_n: 1'b1, rw: 1'b1, uds_n: 1'b1, lds_n: 1'b1,
                                  addr: '0, data: '0};
endpackage

// File: rtl/fb_bus_sync.sv
module fb_bus_sync #(
    parameter int         W      = 1,
    parameter int         STAGES = 2,
    parameter logic [W-1:0] RST  = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    localparam int N = (STAGES < 1) ? 1 : STAGES;

    logic [N-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = d;
        for (int i = 1; i < N; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) chain_q[i] <= RST;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign q = chain_q[N-1];
endmodule

// File: rtl/fb_cfg_decode.sv
module fb_cfg_decode
    import fb_snoop_pkg::*;
(
    input  logic [CFG_W-1:0]  code,
    output logic [BUS_AW-1:0] ram_top,
    output logic              valid
);
    always_comb begin
        valid   = 1'b1;
        ram_top = '0;
        case (code)
            3'd0:    ram_top = 24'h02_0000;
            3'd1:    ram_top = 24'h08_0000;
            3'd2:    ram_top = 24'h10_0000;
            3'd3:    ram_top = 24'h20_0000;
            3'd4:    ram_top = 24'h28_0000;
            3'd5:    ram_top = 24'h40_0000;
            default: valid   = 1'b0;
        endcase
    end
endmodule

// File: rtl/fb_range_check.sv
module fb_range_check
    import fb_snoop_pkg::*;
#(
    parameter int WIN_BYTES = 21888,
    parameter int PRI_BELOW = 'h5900,
    parameter int ALT_BELOW = 'hD900,
    parameter int WA_W      = 14
) (
    input  logic [BUS_AW-1:0] ram_top,
    input  logic [BUS_AW-1:0] byte_addr,
    output logic              hit,
    output logic              page,
    output logic [WA_W-1:0]   word_addr
);
    localparam logic [BUS_AW-1:0] WIN  = BUS_AW'(WIN_BYTES);
    localparam logic [BUS_AW-1:0] PRI  = BUS_AW'(PRI_BELOW);
    localparam logic [BUS_AW-1:0] ALT  = BUS_AW'(ALT_BELOW);

    logic [1:0][BUS_AW-1:0] base;
    logic [1:0][BUS_AW-1:0] offs;
    logic [1:0]             in_win;

    always_comb begin
        base[0] = ram_top - PRI;
        base[1] = ram_top - ALT;
    end

    for (genvar p = 0; p < 2; p++) begin : g_page
        assign offs[p]   = byte_addr - base[p];
        assign in_win[p] = offs[p] < WIN;
    end

    always_comb begin
        hit       = |in_win;
        page      = !in_win[0];
        word_addr = in_win[0] ? offs[0][WA_W:1] : offs[1][WA_W:1];
    end
endmodule

// File: rtl/fb_snoop.sv
module fb_snoop
    import fb_snoop_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int WIN_BYTES   = 21888,
    parameter int PRI_BELOW   = 'h5900,
    parameter int ALT_BELOW   = 'hD900,
    localparam int WORDS      = WIN_BYTES / 2,
    localparam int WA_W       = $clog2(WORDS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CFG_W-1:0]     cfg_ram_sel,
    input  logic                 page_sel,
    input  logic                 bus_as_n,
    input  logic                 bus_rw,
    input  logic                 bus_uds_n,
    input  logic                 bus_lds_n,
    input  logic [BUS_AW-1:1]    bus_addr,
    input  logic [DATA_W-1:0]    bus_data,
    output logic                 cfg_invalid,
    output logic                 disp_page,
    output logic                 wr_valid,
    output logic                 wr_page,
    output logic [WA_W-1:0]      wr_addr,
    output logic [DATA_W-1:0]    wr_data,
    output logic [1:0]           wr_be
);
    typedef struct packed {
        logic [CFG_W-1:0]  cfg;
        logic              cfg_bad;
        logic              disp;
        logic              armed;
        logic              vld;
        logic              pg;
        logic [WA_W-1:0]   wa;
        logic [DATA_W-1:0] dat;
        logic [1:0]        be;
    } state_t;

    state_t st_d, st_q;

    bus_t             bus_raw, bus_s;
    logic [CFG_W-1:0] cfg_s;
    logic             page_s;

    assign bus_raw = '{as_n: bus_as_n, rw: bus_rw, uds_n: bus_uds_n,
                       lds_n: bus_lds_n, addr: bus_addr, data: bus_data};

    fb_bus_sync #(.W(BUS_BITS), .STAGES(SYNC_STAGES), .RST(BUS_IDLE)) u_bus_sync (
        .clk(clk), .rst_n(rst_n), .d(bus_raw), .q(bus_s)
    );

    fb_bus_sync #(.W(CFG_W), .STAGES(SYNC_STAGES), .RST('0)) u_cfg_sync (
        .clk(clk), .rst_n(rst_n), .d(cfg_ram_sel), .q(cfg_s)
    );

    fb_bus_sync #(.W(1), .STAGES(SYNC_STAGES), .RST(1'b0)) u_page_sync (
        .clk(clk), .rst_n(rst_n), .d(page_sel), .q(page_s)
    );

    logic [BUS_AW-1:0] ram_top;
    logic              cfg_ok;
    logic              hit, hit_page;
    logic [WA_W-1:0]   hit_wa;

    fb_cfg_decode u_cfg_decode (
        .code(st_q.cfg), .ram_top(ram_top), .valid(cfg_ok)
    );

    fb_range_check #(
        .WIN_BYTES(WIN_BYTES), .PRI_BELOW(PRI_BELOW),
        .ALT_BELOW(ALT_BELOW), .WA_W(WA_W)
    ) u_range (
        .ram_top(ram_top), .byte_addr({bus_s.addr, 1'b0}),
        .hit(hit), .page(hit_page), .word_addr(hit_wa)
    );

    logic write_now;

    always_comb begin
        st_d      = st_q;
        st_d.cfg  = cfg_s;
        st_d.disp = page_s;
        st_d.cfg_bad = !cfg_ok;
        st_d.vld  = 1'b0;

        // one decision per strobe period: armed while strobe is released
        write_now = st_q.armed && !bus_s.as_n && !bus_s.rw &&
                    (!bus_s.uds_n || !bus_s.lds_n);

        if (bus_s.as_n) begin
            st_d.armed = 1'b1;
        end else if (write_now) begin
            st_d.armed = 1'b0;
        end

        if (write_now && cfg_ok && hit) begin
            st_d.vld = 1'b1;
            st_d.pg  = hit_page;
            st_d.wa  = hit_wa;
            st_d.dat = bus_s.data;
            st_d.be  = {!bus_s.uds_n, !bus_s.lds_n};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.armed <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_invalid = st_q.cfg_bad;
    assign disp_page   = st_q.disp;
    assign wr_valid    = st_q.vld;
    assign wr_page     = st_q.pg;
    assign wr_addr     = st_q.wa;
    assign wr_data     = st_q.dat;
    assign wr_be       = st_q.be;
endmodule

// File: rtl/fb_snoop_chk.sv
module fb_snoop_chk #(
    parameter int WORDS = 10944,
    parameter int WA_W  = 14
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_valid,
    input logic [WA_W-1:0] wr_addr,
    input logic [1:0]      wr_be,
    input logic            cfg_invalid
);
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !wr_valid);

    a_r3_addr_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (int'(wr_addr) < WORDS));

    a_r4_invalid_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_invalid |-> !wr_valid);

    a_r6_be_present: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_be != 2'b00));

    a_r9_reset_idle: assert property (@(posedge clk)
        $rose(rst_n) |-> !wr_valid);
endmodule

bind fb_snoop fb_snoop_chk #(.WORDS(WORDS), .WA_W(WA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_be(wr_be), .cfg_invalid(cfg_invalid)
);

// File: tb/fb_snoop_test.sv
module fb_snoop_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cfg_ram_sel = 3'd5;
    logic        page_sel = 1'b0;
    logic        bus_as_n = 1'b1, bus_rw = 1'b1, bus_uds_n = 1'b1, bus_lds_n = 1'b1;
    logic [23:1] bus_addr = '0;
    logic [15:0] bus_data = '0;
    logic        cfg_invalid, disp_page, wr_valid, wr_page;
    logic [13:0] wr_addr;
    logic [15:0] wr_data;
    logic [1:0]  wr_be;

    int checks = 0, errors = 0, reqs = 0;
    logic        l_page;
    logic [13:0] l_addr;
    logic [15:0] l_data;
    logic [1:0]  l_be;

    always #4 clk = ~clk;

    fb_snoop #(.SYNC_STAGES(3)) uut (.*);

    always @(negedge clk) if (wr_valid) begin
        reqs++;
        l_page = wr_page; l_addr = wr_addr; l_data = wr_data; l_be = wr_be;
    end

    function automatic logic [23:0] top_of(int code);
        case (code)
            0: return 24'h020000; 1: return 24'h080000; 2: return 24'h100000;
            3: return 24'h200000; 4: return 24'h280000; default: return 24'h400000;
        endcase
    endfunction

    task automatic chk(string tag, logic ok, string msg);
        checks++;
        if (!ok) begin errors++; $display("FAIL %s: %s", tag, msg); end
    endtask

    task automatic bus_cycle(logic [23:0] a, logic [15:0] d, logic rw,
                             logic u, logic l, int hold);
        @(negedge clk);
        bus_addr = a[23:1]; bus_data = d; bus_rw = rw; bus_as_n = 1'b0;
        repeat (2) @(negedge clk);
        bus_uds_n = !u; bus_lds_n = !l;
        repeat (hold) @(negedge clk);
        bus_as_n = 1'b1; bus_uds_n = 1'b1; bus_lds_n = 1'b1; bus_rw = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic expect_req(string tag, logic [23:0] a, logic [15:0] d,
                              logic u, logic l, logic pg, int wa);
        int n0 = reqs;
        bus_cycle(a, d, 1'b0, u, l, 4);
        chk(tag, reqs == n0 + 1, $sformatf("count %0d exp %0d", reqs - n0, 1));
        if (reqs == n0 + 1)
            chk(tag, l_page == pg && l_addr == 14'(wa) && l_data == d && l_be == {u, l},
                $sformatf("pg %0b addr %0d data %h be %b exp pg %0b addr %0d data %h be %b",
                          l_page, l_addr, l_data, l_be, pg, wa, d, {u, l}));
    endtask

    task automatic expect_none(string tag, logic [23:0] a, logic rw, logic u, logic l);
        int n0 = reqs;
        bus_cycle(a, 16'hBEEF, rw, u, l, 4);
        chk(tag, reqs == n0, $sformatf("count %0d exp 0", reqs - n0));
    endtask

    task automatic set_cfg(int code);
        cfg_ram_sel = 3'(code);
        repeat (8) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R9", wr_valid == 1'b0, $sformatf("wr_valid %0b exp 0", wr_valid));
    endtask

    task automatic t_primary();
        expect_req("R1", 24'h3FA700, 16'h1234, 1, 1, 0, 0);
        expect_req("R1", 24'h3FA702, 16'hA5A5, 1, 1, 0, 1);
    endtask

    task automatic t_alt();
        expect_req("R2", 24'h3F2700, 16'h0F0F, 1, 1, 1, 0);
    endtask

    task automatic t_bounds();
        expect_req("R3", 24'h3FFC7E, 16'h7777, 1, 1, 0, 10943);
        expect_req("R3", 24'h3F7C7E, 16'h6666, 1, 1, 1, 10943);
        expect_none("R3", 24'h3FFC80, 1'b0, 1, 1);
        expect_none("R3", 24'h3FA6FE, 1'b0, 1, 1);
    endtask

    task automatic t_configs();
        for (int c = 0; c < 6; c++) begin
            set_cfg(c);
            chk("R1", cfg_invalid == 1'b0, $sformatf("cfg_invalid %0b exp 0", cfg_invalid));
            expect_req("R1", top_of(c) - 24'h5900 + 24'h10, 16'(c), 1, 1, 0, 8);
            expect_req("R2", top_of(c) - 24'hD900 + 24'h20, 16'(c + 8), 1, 1, 1, 16);
        end
    endtask

    task automatic t_invalid();
        for (int c = 6; c < 8; c++) begin
            set_cfg(c);
            chk("R4", cfg_invalid == 1'b1, $sformatf("cfg_invalid %0b exp 1", cfg_invalid));
            expect_none("R4", 24'h3FA700, 1'b0, 1, 1);
            expect_none("R4", 24'h01A700, 1'b0, 1, 1);
        end
        set_cfg(5);
    endtask

    task automatic t_read();
        expect_none("R5", 24'h3FA700, 1'b1, 1, 1);
    endtask

    task automatic t_bytes();
        expect_req("R6", 24'h3FA710, 16'hC3D4, 1, 0, 0, 8);
        expect_req("R6", 24'h3FA712, 16'h5A00, 0, 1, 0, 9);
    endtask

    task automatic t_long();
        int n0 = reqs;
        bus_cycle(24'h3FA720, 16'h1111, 1'b0, 1, 1, 40);
        chk("R7", reqs == n0 + 1, $sformatf("count %0d exp 1", reqs - n0));
        n0 = reqs;
        bus_cycle(24'h3FA720, 16'h2222, 1'b0, 1, 1, 4);
        bus_cycle(24'h3FA722, 16'h3333, 1'b0, 1, 1, 4);
        chk("R7", reqs == n0 + 2, $sformatf("count %0d exp 2", reqs - n0));
    endtask

    task automatic t_page();
        page_sel = 1'b1;
        repeat (6) @(negedge clk);
        chk("R8", disp_page == 1'b1, $sformatf("disp_page %0b exp 1", disp_page));
        expect_req("R8", 24'h3FA700, 16'h4444, 1, 1, 0, 0);
        page_sel = 1'b0;
        repeat (6) @(negedge clk);
        chk("R8", disp_page == 1'b0, $sformatf("disp_page %0b exp 0", disp_page));
        expect_req("R8", 24'h3F2702, 16'h5555, 1, 1, 1, 1);
    endtask

    task automatic t_nostrobe();
        expect_none("R11", 24'h3FA700, 1'b0, 0, 0);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (8) @(negedge clk);
        t_reset();
        t_primary();
        t_alt();
        t_bounds();
        t_bytes();
        t_read();
        t_nostrobe();
        t_long();
        t_page();
        t_configs();
        t_invalid();
        t_primary();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: run hung, actual timeout expected completion");
        finish_run();
    end
endmodule